// File: doc/BRIEF.md
# IDE Timing Configuration Register Bank

This block holds the device-specific configuration registers of an IDE disk controller. The registers are two channel timing words, a per-device timing byte, a fast-DMA control byte, a fast-DMA timing word and a controller configuration word. They sit in the part of configuration space at or above a region base offset (0x40 by default). A configuration agent reaches them through a single access port that carries a strobe, a read/write flag, a byte offset, a size code and write data. Offsets below the region base belong to the standard header logic elsewhere, and this block ignores them.

Each register accepts only certain lane and size combinations. Any access inside the region that does not match one of them is refused: it changes no register, a read returns zero, and a sticky error flag is raised. The flag holds until the host acknowledges it. Read data is registered and appears one clock after the request, together with a valid pulse. The stored values are kept for software only and drive no timing logic.

Top module: `ide_timing_cfg`

## Requirements
- R1: After reset, both channel timing words read 0x8000 (bit 15 is the decode-enable bit). The device timing byte, the fast-DMA control byte, the fast-DMA timing word and the configuration word read 0. The error flag and the read-valid output are 0.
- R2: A halfword access (size code 1) at offset 0x40 (primary timing), 0x42 (secondary timing), 0x4A (fast-DMA timing) or 0x54 (configuration word) writes bits 15:0 of the write data, or returns the register in read-data bits 15:0 with the upper bits zero.
- R3: A byte access (size code 0) at 0x44 (device timing) or 0x48 (fast-DMA control) writes write-data bits 7:0, or returns the register in read-data bits 7:0 with the upper bits zero.
- R4: A byte read at 0x41 or 0x43 returns bits 15:8 of the primary or the secondary timing word. A byte write at either offset is refused.
- R5: A byte write at 0x54 replaces only bits 7:0 of the configuration word, and a byte write at 0x55 replaces only bits 15:8. Byte reads at those offsets return the matching half.
- R6: Any access in the region with size code 2 (four bytes) or size code 3 (reserved) is refused.
- R7: Any other byte or halfword offset in the region is refused. A refused access changes no register and, when it is a read, returns all-zero read data.
- R8: An access below the region base changes no register, raises no error and produces no read-valid pulse.
- R9: A refused access sets the error flag. The flag stays set until the acknowledge input is high in a cycle with no new refused access. A refused access in the same cycle as an acknowledge leaves the flag set.
- R10: Every read in the region, whether accepted or refused, produces a one-cycle read-valid pulse with its data on the clock edge after the request. Writes produce none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgValid | input | 1 | Access request strobe, one cycle per access |
| cfgWrite | input | 1 | 1 for a write, 0 for a read |
| cfgOffset | input | OFF_W | Byte offset in configuration space |
| cfgSize | input | 2 | Size code: 0 byte, 1 halfword, 2 four bytes, 3 reserved |
| cfgWrData | input | REG_W | Write data, right-aligned |
| errAck | input | 1 | Clears the sticky error flag |
| cfgRdData | output | DATA_W | Registered read data, zero-extended |
| cfgRdValid | output | 1 | Read data valid, one cycle after a read in the region |
| errFlag | output | 1 | Sticky flag for refused accesses |

## Verification
The bench builds the block with its default parameters: an 8-bit offset, a 16-bit register width, a 32-bit read port and the region starting at 0x40. With an 8-bit offset, every one of the 256 offsets can be driven with all four size codes, both as reads and as writes. The sweep therefore covers every accepted lane, every refused combination and every access below the region base. After each write, all six registers are read back and compared with an arithmetic model kept in the bench, so any stray update is caught. Separate short sequences cover the split halves of the configuration word and the priority between acknowledge and a new error.

// File: rtl/ide_tcfg_pkg.sv
package ide_tcfg_pkg;

  // Access size codes on the configuration port
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } accSize_e;

  // Register offsets; neighbouring software decodes these
  localparam logic [7:0] OFF_PRI_TIM  = 8'h40;
  localparam logic [7:0] OFF_SEC_TIM  = 8'h42;
  localparam logic [7:0] OFF_DEV_TIM  = 8'h44;
  localparam logic [7:0] OFF_FDMA_CTL = 8'h48;
  localparam logic [7:0] OFF_FDMA_TIM = 8'h4A;
  localparam logic [7:0] OFF_CTL_CFG  = 8'h54;

  // Timing words come up with decode enabled
  localparam logic [15:0] TIM_RESET = 16'h8000;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_PRI,
    SEL_PRI_HI,
    SEL_SEC,
    SEL_SEC_HI,
    SEL_DEV,
    SEL_FCTL,
    SEL_FTIM,
    SEL_CFG,
    SEL_CFG_LO,
    SEL_CFG_HI
  } rdSel_e;

  typedef struct packed {
    logic   wrPri;
    logic   wrSec;
    logic   wrDev;
    logic   wrFctl;
    logic   wrFtim;
    logic   wrCfgLo;
    logic   wrCfgHi;
    logic   rdEn;
    rdSel_e rdSel;
    logic   accErr;
  } strobe_t;

endpackage

// File: rtl/ide_tcfg_ctrl.sv
module ide_tcfg_ctrl
  import ide_tcfg_pkg::*;
#(
  parameter int OFF_W = 8,
  parameter logic [OFF_W-1:0] REGION_BASE = 'h40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accValid,
  input  logic             accWrite,
  input  logic [OFF_W-1:0] accOffset,
  input  logic [1:0]       accSize,
  input  logic             errAck,
  output strobe_t          strobes,
  output logic             errFlag
);

  localparam logic [OFF_W-1:0] L_PRI    = OFF_W'(OFF_PRI_TIM);
  localparam logic [OFF_W-1:0] L_PRI_HI = OFF_W'(OFF_PRI_TIM + 8'd1);
  localparam logic [OFF_W-1:0] L_SEC    = OFF_W'(OFF_SEC_TIM);
  localparam logic [OFF_W-1:0] L_SEC_HI = OFF_W'(OFF_SEC_TIM + 8'd1);
  localparam logic [OFF_W-1:0] L_DEV    = OFF_W'(OFF_DEV_TIM);
  localparam logic [OFF_W-1:0] L_FCTL   = OFF_W'(OFF_FDMA_CTL);
  localparam logic [OFF_W-1:0] L_FTIM   = OFF_W'(OFF_FDMA_TIM);
  localparam logic [OFF_W-1:0] L_CFG    = OFF_W'(OFF_CTL_CFG);
  localparam logic [OFF_W-1:0] L_CFG_HI = OFF_W'(OFF_CTL_CFG + 8'd1);

  logic   inRegion;
  logic   hit;
  logic   legal;
  rdSel_e selDec;
  logic [6:0] wrDec;  // pri, sec, dev, fctl, ftim, cfgLo, cfgHi

  assign inRegion = (accOffset >= REGION_BASE);
  assign hit      = accValid && inRegion;

  // Lane decode: which size/offset pairs are accepted and what they touch
  always_comb begin
    legal  = 1'b0;
    selDec = SEL_NONE;
    wrDec  = '0;
    case (accSize)
      SZ_HALF: begin
        case (accOffset)
          L_PRI:   begin legal = 1'b1; selDec = SEL_PRI;  wrDec[6] = 1'b1; end
          L_SEC:   begin legal = 1'b1; selDec = SEL_SEC;  wrDec[5] = 1'b1; end
          L_FTIM:  begin legal = 1'b1; selDec = SEL_FTIM; wrDec[2] = 1'b1; end
          L_CFG:   begin legal = 1'b1; selDec = SEL_CFG;  wrDec[1:0] = 2'b11; end
          default: legal = 1'b0;
        endcase
      end
      SZ_BYTE: begin
        case (accOffset)
          L_DEV:    begin legal = 1'b1; selDec = SEL_DEV;    wrDec[4] = 1'b1; end
          L_FCTL:   begin legal = 1'b1; selDec = SEL_FCTL;   wrDec[3] = 1'b1; end
          L_CFG:    begin legal = 1'b1; selDec = SEL_CFG_LO; wrDec[1] = 1'b1; end
          L_CFG_HI: begin legal = 1'b1; selDec = SEL_CFG_HI; wrDec[0] = 1'b1; end
          L_PRI_HI: begin legal = !accWrite; selDec = SEL_PRI_HI; end
          L_SEC_HI: begin legal = !accWrite; selDec = SEL_SEC_HI; end
          default:  legal = 1'b0;
        endcase
      end
      default: legal = 1'b0;
    endcase
  end

  logic doWrite;
  assign doWrite = hit && accWrite && legal;

  always_comb begin
    strobes.wrPri   = doWrite && wrDec[6];
    strobes.wrSec   = doWrite && wrDec[5];
    strobes.wrDev   = doWrite && wrDec[4];
    strobes.wrFctl  = doWrite && wrDec[3];
    strobes.wrFtim  = doWrite && wrDec[2];
    strobes.wrCfgLo = doWrite && wrDec[1];
    strobes.wrCfgHi = doWrite && wrDec[0];
    strobes.rdEn    = hit && !accWrite;
    strobes.rdSel   = (hit && !accWrite && legal) ? selDec : SEL_NONE;
    strobes.accErr  = hit && !legal;
  end

  // Sticky error: a new refusal outranks the acknowledge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              errFlag <= 1'b0;
    else if (strobes.accErr) errFlag <= 1'b1;
    else if (errAck)         errFlag <= 1'b0;
  end

endmodule

// File: rtl/ide_tcfg_dp.sv
module ide_tcfg_dp
  import ide_tcfg_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strobes,
  input  logic [REG_W-1:0]  wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  localparam int BYTE_W = REG_W / 2;

  logic [REG_W-1:0]  priTim, secTim, fdmaTim, ctlCfg;
  logic [BYTE_W-1:0] devTim, fdmaCtl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      priTim  <= REG_W'(TIM_RESET);
      secTim  <= REG_W'(TIM_RESET);
      fdmaTim <= '0;
      ctlCfg  <= '0;
      devTim  <= '0;
      fdmaCtl <= '0;
    end else begin
      if (strobes.wrPri)   priTim  <= wrData;
      if (strobes.wrSec)   secTim  <= wrData;
      if (strobes.wrFtim)  fdmaTim <= wrData;
      if (strobes.wrDev)   devTim  <= wrData[BYTE_W-1:0];
      if (strobes.wrFctl)  fdmaCtl <= wrData[BYTE_W-1:0];
      // A halfword write raises both strobes; a byte write to the upper lane
      // carries its data in the low byte of the bus.
      if (strobes.wrCfgLo) ctlCfg[BYTE_W-1:0] <= wrData[BYTE_W-1:0];
      if (strobes.wrCfgHi) ctlCfg[REG_W-1:BYTE_W] <=
          (strobes.wrCfgLo ? wrData[REG_W-1:BYTE_W] : wrData[BYTE_W-1:0]);
    end
  end

  logic [REG_W-1:0] muxOut;

  always_comb begin
    case (strobes.rdSel)
      SEL_PRI:    muxOut = priTim;
      SEL_PRI_HI: muxOut = REG_W'(priTim[REG_W-1:BYTE_W]);
      SEL_SEC:    muxOut = secTim;
      SEL_SEC_HI: muxOut = REG_W'(secTim[REG_W-1:BYTE_W]);
      SEL_DEV:    muxOut = REG_W'(devTim);
      SEL_FCTL:   muxOut = REG_W'(fdmaCtl);
      SEL_FTIM:   muxOut = fdmaTim;
      SEL_CFG:    muxOut = ctlCfg;
      SEL_CFG_LO: muxOut = REG_W'(ctlCfg[BYTE_W-1:0]);
      SEL_CFG_HI: muxOut = REG_W'(ctlCfg[REG_W-1:BYTE_W]);
      default:    muxOut = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strobes.rdEn;
      rdData  <= strobes.rdEn ? DATA_W'(muxOut) : '0;
    end
  end

endmodule

// File: rtl/ide_timing_cfg.sv
module ide_timing_cfg
  import ide_tcfg_pkg::*;
#(
  parameter int OFF_W  = 8,
  parameter int REG_W  = 16,
  parameter int DATA_W = 32,
  parameter logic [OFF_W-1:0] REGION_BASE = 'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgValid,
  input  logic              cfgWrite,
  input  logic [OFF_W-1:0]  cfgOffset,
  input  logic [1:0]        cfgSize,
  input  logic [REG_W-1:0]  cfgWrData,
  input  logic              errAck,
  output logic [DATA_W-1:0] cfgRdData,
  output logic              cfgRdValid,
  output logic              errFlag
);

  strobe_t strobes;

  ide_tcfg_ctrl #(
    .OFF_W      (OFF_W),
    .REGION_BASE(REGION_BASE)
  ) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .accValid (cfgValid),
    .accWrite (cfgWrite),
    .accOffset(cfgOffset),
    .accSize  (cfgSize),
    .errAck   (errAck),
    .strobes  (strobes),
    .errFlag  (errFlag)
  );

  ide_tcfg_dp #(
    .REG_W (REG_W),
    .DATA_W(DATA_W)
  ) dp_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobes(strobes),
    .wrData (cfgWrData),
    .rdData (cfgRdData),
    .rdValid(cfgRdValid)
  );

endmodule

// File: rtl/ide_timing_cfg_chk.sv
module ide_timing_cfg_chk #(
  parameter int OFF_W  = 8,
  parameter int REG_W  = 16,
  parameter int DATA_W = 32,
  parameter logic [OFF_W-1:0] REGION_BASE = 'h40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfgValid,
  input logic              cfgWrite,
  input logic [OFF_W-1:0]  cfgOffset,
  input logic [1:0]        cfgSize,
  input logic [REG_W-1:0]  cfgWrData,
  input logic              errAck,
  input logic [DATA_W-1:0] cfgRdData,
  input logic              cfgRdValid,
  input logic              errFlag
);

  logic regionRead, regionAny, wideAcc;
  assign regionAny  = cfgValid && (cfgOffset >= REGION_BASE);
  assign regionRead = regionAny && !cfgWrite;
  assign wideAcc    = regionAny && cfgSize[1];

  // R10
  rd_valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    regionRead |=> cfgRdValid);

  // R10
  rd_valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !regionRead |=> !cfgRdValid);

  // R6
  wide_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wideAcc |=> errFlag);

  // R7
  wide_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wideAcc && !cfgWrite) |=> (cfgRdData == '0));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (errFlag && !errAck) |=> errFlag);

  // R8
  low_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!errFlag && !regionAny) |=> !errFlag);

endmodule

bind ide_timing_cfg ide_timing_cfg_chk #(
  .OFF_W(OFF_W), .REG_W(REG_W), .DATA_W(DATA_W), .REGION_BASE(REGION_BASE)
) chk_i (.*);

// File: tb/ide_timing_cfg_tb_top.sv
module ide_timing_cfg_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfgValid = 1'b0;
  logic        cfgWrite = 1'b0;
  logic [7:0]  cfgOffset = '0;
  logic [1:0]  cfgSize = '0;
  logic [15:0] cfgWrData = '0;
  logic        errAck = 1'b0;
  logic [31:0] cfgRdData;
  logic        cfgRdValid;
  logic        errFlag;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  ide_timing_cfg dut_i (
    .clk(clk), .rst_n(rst_n), .cfgValid(cfgValid), .cfgWrite(cfgWrite),
    .cfgOffset(cfgOffset), .cfgSize(cfgSize), .cfgWrData(cfgWrData),
    .errAck(errAck), .cfgRdData(cfgRdData), .cfgRdValid(cfgRdValid),
    .errFlag(errFlag)
  );

  // Bench model of the register contents
  logic [15:0] mPri, mSec, mFtim, mCfg;
  logic [7:0]  mDev, mFctl;

  function automatic bit wrOk(input logic [7:0] off, input logic [1:0] sz);
    if (sz == 2'd1) return off inside {8'h40, 8'h42, 8'h4A, 8'h54};
    if (sz == 2'd0) return off inside {8'h44, 8'h48, 8'h54, 8'h55};
    return 1'b0;
  endfunction

  function automatic bit rdOk(input logic [7:0] off, input logic [1:0] sz);
    if (sz == 2'd0 && off inside {8'h41, 8'h43}) return 1'b1;
    return wrOk(off, sz);
  endfunction

  function automatic logic [31:0] modelRead(input logic [7:0] off, input logic [1:0] sz);
    if (!rdOk(off, sz)) return 32'h0;
    if (sz == 2'd1) begin
      case (off)
        8'h40:   return {16'h0, mPri};
        8'h42:   return {16'h0, mSec};
        8'h4A:   return {16'h0, mFtim};
        default: return {16'h0, mCfg};
      endcase
    end
    case (off)
      8'h41:   return {24'h0, mPri[15:8]};
      8'h43:   return {24'h0, mSec[15:8]};
      8'h44:   return {24'h0, mDev};
      8'h48:   return {24'h0, mFctl};
      8'h54:   return {24'h0, mCfg[7:0]};
      default: return {24'h0, mCfg[15:8]};
    endcase
  endfunction

  task automatic modelWrite(input logic [7:0] off, input logic [1:0] sz, input logic [15:0] d);
    if (off < 8'h40 || !wrOk(off, sz)) return;
    if (sz == 2'd1) begin
      case (off)
        8'h40:   mPri  = d;
        8'h42:   mSec  = d;
        8'h4A:   mFtim = d;
        default: mCfg  = d;
      endcase
    end else begin
      case (off)
        8'h44:   mDev       = d[7:0];
        8'h48:   mFctl      = d[7:0];
        8'h54:   mCfg[7:0]  = d[7:0];
        default: mCfg[15:8] = d[7:0];
      endcase
    end
  endtask

  function automatic string tagFor(input logic [7:0] off, input logic [1:0] sz, input bit wr);
    if (off < 8'h40) return "R8";
    if (sz[1]) return "R6";
    if (off inside {8'h41, 8'h43} && sz == 2'd0) return "R4";
    if (wr ? !wrOk(off, sz) : !rdOk(off, sz)) return "R7";
    if (off inside {8'h54, 8'h55} && sz == 2'd0) return "R5";
    if (sz == 2'd0) return "R3";
    return "R2";
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // One access: drive on a falling edge, sample on the next falling edge,
  // acknowledge any error so the next access starts clean.
  task automatic doAcc(input bit wr, input logic [7:0] off, input logic [1:0] sz,
                       input logic [15:0] d, output logic [31:0] rd,
                       output logic rv, output logic ef);
    @(negedge clk);
    cfgValid = 1'b1; cfgWrite = wr; cfgOffset = off; cfgSize = sz; cfgWrData = d;
    @(negedge clk);
    cfgValid = 1'b0; cfgWrite = 1'b0;
    rd = cfgRdData; rv = cfgRdValid; ef = errFlag;
    if (ef) begin
      errAck = 1'b1;
      @(negedge clk);
      errAck = 1'b0;
    end
  endtask

  task automatic readCheck(input logic [7:0] off, input logic [1:0] sz, input string tag);
    logic [31:0] rd; logic rv, ef;
    doAcc(1'b0, off, sz, 16'h0, rd, rv, ef);
    check(tag, $sformatf("read data off %h size %0d", off, sz), rd, modelRead(off, sz));
  endtask

  task automatic readbackAll(input string tag);
    readCheck(8'h40, 2'd1, tag);
    readCheck(8'h42, 2'd1, tag);
    readCheck(8'h44, 2'd0, tag);
    readCheck(8'h48, 2'd0, tag);
    readCheck(8'h4A, 2'd1, tag);
    readCheck(8'h54, 2'd1, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd; logic rv, ef;
    mPri = 16'h8000; mSec = 16'h8000; mFtim = '0; mCfg = '0; mDev = '0; mFctl = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    check("R1", "errFlag after reset", {31'h0, errFlag}, 32'h0);
    check("R1", "rdValid after reset", {31'h0, cfgRdValid}, 32'h0);
    readbackAll("R1");

    // Read sweep over every offset and size code
    for (int o = 0; o < 256; o++) begin
      for (int s = 0; s < 4; s++) begin
        logic [7:0] off; logic [1:0] sz; string tg;
        off = 8'(o); sz = 2'(s); tg = tagFor(off, sz, 1'b0);
        doAcc(1'b0, off, sz, 16'h0, rd, rv, ef);
        check(tg, $sformatf("read data off %h size %0d", off, sz), rd,
              (off >= 8'h40) ? modelRead(off, sz) : 32'h0);
        check((off < 8'h40) ? "R8" : "R10", $sformatf("rdValid off %h", off),
              {31'h0, rv}, {31'h0, off >= 8'h40});
        check(tg, $sformatf("errFlag read off %h size %0d", off, sz), {31'h0, ef},
              {31'h0, (off >= 8'h40) && !rdOk(off, sz)});
      end
    end

    // Write sweep, every register read back after each write
    for (int o = 0; o < 256; o++) begin
      for (int s = 0; s < 4; s++) begin
        logic [7:0] off; logic [1:0] sz; logic [15:0] d; string tg;
        off = 8'(o); sz = 2'(s); tg = tagFor(off, sz, 1'b1);
        d = {off ^ 8'h3C, off + 8'h11 + 8'(s)};
        doAcc(1'b1, off, sz, d, rd, rv, ef);
        check("R10", $sformatf("rdValid on write off %h", off), {31'h0, rv}, 32'h0);
        check(tg, $sformatf("errFlag write off %h size %0d", off, sz), {31'h0, ef},
              {31'h0, (off >= 8'h40) && !wrOk(off, sz)});
        modelWrite(off, sz, d);
        readbackAll(tg);
      end
    end

    // R5: split halves of the configuration word
    doAcc(1'b1, 8'h54, 2'd1, 16'h1234, rd, rv, ef);
    doAcc(1'b1, 8'h55, 2'd0, 16'h77AB, rd, rv, ef);
    doAcc(1'b0, 8'h54, 2'd1, 16'h0, rd, rv, ef);
    check("R5", "cfg after upper byte write", rd, 32'h0000AB34);
    doAcc(1'b1, 8'h54, 2'd0, 16'h66CD, rd, rv, ef);
    doAcc(1'b0, 8'h54, 2'd1, 16'h0, rd, rv, ef);
    check("R5", "cfg after lower byte write", rd, 32'h0000ABCD);
    doAcc(1'b0, 8'h55, 2'd0, 16'h0, rd, rv, ef);
    check("R5", "cfg upper byte read", rd, 32'h000000AB);

    // R9: sticky flag, acknowledge priority
    @(negedge clk);
    cfgValid = 1'b1; cfgWrite = 1'b1; cfgOffset = 8'h46; cfgSize = 2'd0;
    @(negedge clk);
    cfgValid = 1'b0;
    repeat (3) @(negedge clk);
    check("R9", "flag holds without ack", {31'h0, errFlag}, 32'h1);
    cfgValid = 1'b1; cfgWrite = 1'b0; cfgOffset = 8'h60; cfgSize = 2'd2; errAck = 1'b1;
    @(negedge clk);
    cfgValid = 1'b0;
    check("R9", "new error beats ack", {31'h0, errFlag}, 32'h1);
    @(negedge clk);
    errAck = 1'b0;
    check("R9", "ack alone clears", {31'h0, errFlag}, 32'h0);
    @(negedge clk);
    check("R9", "flag stays clear", {31'h0, errFlag}, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule